// File: doc/BRIEF.md
# Output DC Offset Persistence Detector

This block decides, for each amplifier output channel, whether a DC offset has been present for the whole of a measurement window that the host sets. Each channel supplies a comparator flag, already synchronized to the block clock, that is high while the output sits more than about 2 V away from its mid-point. The block does not time the window itself. A window opens when the host sets the offset-enable control bit, and each status read that arrives while the bit is set opens a new one. A window closes at the next status read, and that read returns the verdict for the window that just closed.

A channel is reported as offset only if its flag was high in every cycle of the window. One low sample anywhere in the window clears that channel's verdict. A short-circuit protection trip on any channel during the window voids the measurement. Every channel then reports no offset at the closing read, and the detector stays idle until the next window opens. An activity output tells the host whether a measurement is currently running.

Top module: `dc_offset_watch`

## Requirements
- R1: After reset, every result bit and the activity output are 0.
- R2: When the enable input changes from 0 to 1 in a cycle, a window starts at that clock edge. If no trip input is high in that cycle, the activity output is 1 from the next cycle on.
- R3: A read strobe (one cycle high on `rd_stb`) while enable is 1 closes the current window and opens the next one at the same edge, so consecutive reads bound back-to-back windows.
- R4: At a read that closes a live window, result bit c becomes 1 only if `lvl[c]` was 1 in every cycle after the opening edge up to and including the read cycle. The new value is visible in the cycle after the read.
- R5: A single low cycle of `lvl[c]` anywhere in the window, including its first cycle and the read cycle, makes result bit c 0. Channels are judged independently.
- R6: If any `trip` bit is high in a cycle, the activity output is 0 in the next cycle. The next read returns all zeros, and when enable is still 1 that read opens a fresh window.
- R7: Result bits change only in the cycle after a read strobe and hold their value otherwise.
- R8: While enable is 0 the activity output is 0 from the next cycle on, and a read returns all zeros.
- R9: A read while the activity output is 0 returns all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ofs_en | input | 1 | Offset-detection enable control bit (level) |
| rd_stb | input | 1 | One-cycle strobe for a host status read |
| lvl | input | NUM_CH | Synchronized offset comparator flag per channel |
| trip | input | NUM_CH | Short-circuit protection trip per channel |
| result | output | NUM_CH | Per-channel offset verdict from the last closed window |
| active | output | 1 | A measurement window is running |

## Verification
The bench builds the block with its default four channels and three-cycle windows between reads. With those values it can sweep all 4096 combinations of comparator samples across back-to-back windows. That sweep puts every position of a single low sample, and every mix of channels, against a verdict computed as a plain AND of each channel's samples. Directed sequences then trip a protection input in the middle of a window and drop the enable bit. They also hold off reads while the flags toggle, which checks voiding, re-arming and the holding of results.

// File: rtl/ofsd_pkg.sv
package ofsd_pkg;

  // Verdict for one channel when its window closes.
  function automatic logic chan_verdict(input logic live,
                                        input logic voided,
                                        input logic level_now,
                                        input logic dropped);
    return live & ~voided & level_now & ~dropped;
  endfunction

  // Next state of the sticky "went low" mark while a window runs.
  function automatic logic drop_mark(input logic mark, input logic level_now);
    return mark | ~level_now;
  endfunction

endpackage

// File: rtl/ofsd_window.sv
module ofsd_window (
  input  logic clk,
  input  logic rst_n,
  input  logic ofs_en,
  input  logic rd_stb,
  input  logic any_trip,
  output logic win_start,
  output logic win_live
);

  logic en_q;
  logic en_rise;

  assign en_rise   = ofs_en & ~en_q;
  assign win_start = en_rise | (rd_stb & ofs_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      win_live <= 1'b0;
    end else begin
      en_q <= ofs_en;
      if (any_trip)
        win_live <= 1'b0;
      else if (win_start)
        win_live <= 1'b1;
      else if (!ofs_en)
        win_live <= 1'b0;
    end
  end

endmodule

// File: rtl/ofsd_lane.sv
module ofsd_lane
  import ofsd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic win_start,
  input  logic win_live,
  input  logic win_void,
  input  logic win_stop,
  input  logic level,
  output logic res
);

  logic went_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      went_low <= 1'b0;
    end else if (win_start) begin
      went_low <= 1'b0;
    end else if (win_live) begin
      went_low <= drop_mark(went_low, level);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= 1'b0;
    end else if (win_stop) begin
      res <= chan_verdict(win_live, win_void, level, went_low);
    end
  end

endmodule

// File: rtl/dc_offset_watch.sv
module dc_offset_watch #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ofs_en,
  input  logic              rd_stb,
  input  logic [NUM_CH-1:0] lvl,
  input  logic [NUM_CH-1:0] trip,
  output logic [NUM_CH-1:0] result,
  output logic              active
);

  logic any_trip;
  logic win_start;
  logic win_live;

  assign any_trip = |trip;

  ofsd_window u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .ofs_en    (ofs_en),
    .rd_stb    (rd_stb),
    .any_trip  (any_trip),
    .win_start (win_start),
    .win_live  (win_live)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    ofsd_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_start (win_start),
      .win_live  (win_live),
      .win_void  (any_trip),
      .win_stop  (rd_stb),
      .level     (lvl[c]),
      .res       (result[c])
    );
  end

  assign active = win_live;

endmodule

// File: rtl/ofsd_checker.sv
module ofsd_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ofs_en,
  input logic              rd_stb,
  input logic [NUM_CH-1:0] lvl,
  input logic [NUM_CH-1:0] trip,
  input logic [NUM_CH-1:0] result,
  input logic              active,
  input logic              win_start
);

  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start && !(|trip)) |=> active);

  a_r4_level_at_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((result & ~$past(lvl)) == '0));

  a_r6_trip_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (|trip) |=> !active);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(result));

  a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ofs_en |=> !active);

  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !active) |=> (result == '0));

endmodule

bind dc_offset_watch ofsd_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ofs_en    (ofs_en),
  .rd_stb    (rd_stb),
  .lvl       (lvl),
  .trip      (trip),
  .result    (result),
  .active    (active),
  .win_start (win_start)
);

// File: tb/tb_dc_offset_watch.sv
module tb_dc_offset_watch;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ofs_en = 1'b0;
  logic          rd_stb = 1'b0;
  logic [NC-1:0] lvl = '0;
  logic [NC-1:0] trip = '0;
  logic [NC-1:0] result;
  logic          active;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dc_offset_watch #(.NUM_CH(NC)) dut (
    .clk(clk), .rst_n(rst_n), .ofs_en(ofs_en), .rd_stb(rd_stb),
    .lvl(lvl), .trip(trip), .result(result), .active(active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle's inputs at the falling edge.
  task automatic cyc(input logic en, input logic rd, input logic [NC-1:0] lv,
                     input logic [NC-1:0] tp);
    @(negedge clk);
    ofs_en = en; rd_stb = rd; lvl = lv; trip = tp;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [NC-1:0] expv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 result", 32'(result), 0);
    chk("R1 active", 32'(active), 0);

    // R2: enable rising edge opens a window
    cyc(1'b0, 1'b0, '0, '0);
    cyc(1'b1, 1'b0, '0, '0);
    cyc(1'b1, 1'b0, 4'hF, '0);
    chk("R2 active after enable", 32'(active), 1);

    // Sweep (R4 R5 R3): three-sample windows, all 4096 sample combinations
    expv = '0;
    for (int p = 0; p < 4096; p++) begin
      logic [11:0] pv;
      pv = 12'(p);
      if (p != 0) begin
        cyc(1'b1, 1'b0, pv[3:0], '0);
        chk("R4/R5 sweep verdict", 32'(result), 32'(expv));
        chk("R3 still active", 32'(active), 1);
      end
      else begin
        // first window already has one sample (4'hF) driven above; restart it cleanly
        cyc(1'b1, 1'b1, 4'hF, '0);
        cyc(1'b1, 1'b0, pv[3:0], '0);
      end
      cyc(1'b1, 1'b0, pv[7:4], '0);
      cyc(1'b1, 1'b1, pv[11:8], '0);
      expv = pv[3:0] & pv[7:4] & pv[11:8];
    end
    cyc(1'b1, 1'b0, 4'hF, '0);
    chk("R4 last sweep verdict", 32'(result), 32'(expv));

    // R7: results hold while flags toggle without reads
    cyc(1'b1, 1'b1, 4'hA, '0);  // closes window of {F,A}: verdict A
    cyc(1'b1, 1'b0, 4'h5, '0);
    chk("R7 verdict captured", 32'(result), 32'hA);
    cyc(1'b1, 1'b0, 4'h0, '0);
    cyc(1'b1, 1'b0, 4'hF, '0);
    cyc(1'b1, 1'b0, 4'h3, '0);
    chk("R7 held without read", 32'(result), 32'hA);

    // R6: trip mid-window voids, next read restarts
    cyc(1'b1, 1'b1, 4'hF, '0);      // new window
    cyc(1'b1, 1'b0, 4'hF, '0);
    cyc(1'b1, 1'b0, 4'hF, 4'h4);    // trip on channel 2
    cyc(1'b1, 1'b0, 4'hF, '0);
    chk("R6 active drops after trip", 32'(active), 0);
    cyc(1'b1, 1'b1, 4'hF, '0);      // read while voided
    cyc(1'b1, 1'b0, 4'hF, '0);
    chk("R6 voided read zero", 32'(result), 0);
    chk("R6 read re-arms", 32'(active), 1);
    cyc(1'b1, 1'b1, 4'hF, '0);
    cyc(1'b1, 1'b0, 4'hF, '0);
    chk("R6 clean window after re-arm", 32'(result), 32'hF);

    // R5: a low in the read cycle only
    cyc(1'b1, 1'b1, 4'h7, '0);
    cyc(1'b1, 1'b0, 4'hF, '0);
    chk("R5 low at read cycle", 32'(result), 32'h7);

    // R8: enable low
    cyc(1'b0, 1'b0, 4'hF, '0);
    cyc(1'b0, 1'b0, 4'hF, '0);
    chk("R8 active low when disabled", 32'(active), 0);
    cyc(1'b0, 1'b1, 4'hF, '0);
    cyc(1'b0, 1'b0, 4'hF, '0);
    chk("R8 read while disabled", 32'(result), 0);
    chk("R9 idle read gives zero", 32'(active), 0);

    // R2: re-enable opens window, trip in start cycle keeps it idle
    cyc(1'b1, 1'b0, 4'hF, 4'h1);
    cyc(1'b1, 1'b0, 4'hF, '0);
    chk("R2 trip at start keeps idle", 32'(active), 0);
    cyc(1'b1, 1'b1, 4'hF, '0);
    cyc(1'b1, 1'b0, 4'hF, '0);
    chk("R9 read after idle start zero", 32'(result), 0);
    chk("R3 read opens window", 32'(active), 1);

    finish_run();
  end
endmodule